// File: doc/BRIEF.md
# Receive Buffer with Fill-Level and Idle Interrupt

This block sits between a UART receiver's deserializer and the host. Each received byte is stored in a FIFO whose capacity is chosen by a depth-select pin: 8 or 16 entries. The host drains the FIFO through a valid/ready read port. The read side follows these rules:
- `rd_valid` is high whenever at least one byte is stored.
- `rd_data` always shows the oldest stored byte.
- A byte is removed in a cycle where both `rd_valid` and `rd_ready` are high.
- The host may hold `rd_ready` low for as long as it likes; bytes stay stored.

The receive side has no back-pressure, because a serial line cannot be stalled. A byte offered while the FIFO is full is dropped, and this is recorded in a sticky overrun flag.

The receive interrupt has two sources:
- **Fill level.** A two-bit code, `{lvl_hi, lvl_lo}`, sets the fill threshold that raises the interrupt. The threshold table depends on the selected depth.
- **Idle watchdog (optional).** It raises the interrupt when stored bytes have gone untouched for 64 receiver bit times. This catches the tail of a message that is too short to reach the threshold.

Changing the depth selection empties the FIFO.

Top module: `rx_fifo_irq`

## Requirements
- R1: With `depth_sel`=0 the FIFO holds up to 8 bytes, and with `depth_sel`=1 it holds up to 16. `fill_count` gives the number stored, and `full` is high exactly when `fill_count` equals the capacity.
- R2: `rd_valid` is high iff `fill_count` is nonzero, and `rd_data` is the oldest stored byte. A byte is popped on a clock edge where `rd_valid` and `rd_ready` are both high. Bytes leave in the order they arrived.
- R3: When `rx_wr_en` is high while `full` is high (even if a pop happens in the same cycle), the byte is discarded and `overrun` is set on the next edge. `overrun` stays set until `ovr_clr` is high at a clock edge with no new overrun. A new overrun takes priority over the clear.
- R4: At 8-entry depth, `irq` is high from the threshold when `fill_count` is at least 1, 3, 6 or 8 for level codes {`lvl_hi`,`lvl_lo`} = 00, 01, 10 and 11.
- R5: At 16-entry depth, the thresholds for codes 00, 01, 10 and 11 are 1, 8, 12 and 16.
- R6: With `wdog_en`=1 and the FIFO non-empty, a cycle with `bit_tick` high counts one bit time. On the 64th counted bit time after the last FIFO access, a watchdog flag is set on that edge. The flag holds `irq` high until the next access.
- R7: A push (an accepted write) or a pop restarts the bit-time count from zero, and also clears the watchdog flag.
- R8: While `wdog_en`=0, the count and the flag are held at zero, so the watchdog never raises `irq`.
- R9: On a clock edge where `depth_sel` differs from the depth currently in use, the FIFO is emptied and the watchdog is reset. A write or a read in that same cycle is ignored.
- R10: `irq` is the OR of the threshold condition and the watchdog flag. It is low whenever the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_wr_en | input | 1 | Received byte strobe |
| rx_wr_data | input | 8 | Received byte |
| rd_valid | output | 1 | A stored byte is available |
| rd_ready | input | 1 | Host takes the byte |
| rd_data | output | 8 | Oldest stored byte |
| bit_tick | input | 1 | One receiver 1x bit time |
| depth_sel | input | 1 | 0: 8 entries, 1: 16 entries |
| wdog_en | input | 1 | Watchdog enable |
| lvl_hi | input | 1 | Upper bit of the level code |
| lvl_lo | input | 1 | Lower bit of the level code |
| ovr_clr | input | 1 | Clear the overrun flag |
| fill_count | output | 5 | Bytes stored |
| full | output | 1 | FIFO at capacity |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt |

## Verification
The bench uses the default parameters: 8-bit data and a 64-bit-time watchdog. Because of this, the exact 64th-tick firing edge can be reached with a short run of consecutive ticks. Every entry of both threshold tables, and both capacities, can be reached by filling the FIFO from empty. Random traffic with sparse ticks covers simultaneous push and pop at full, and writes to a full FIFO. It also covers depth changes in the middle of a stream.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned DEPTH_LG = 16;
  localparam int unsigned DEPTH_SM = 8;
  localparam int unsigned PTR_W    = $clog2(DEPTH_LG);
  localparam int unsigned CNT_W    = PTR_W + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  // Fill threshold for a depth choice and a two-bit level code.
  function automatic cnt_t level_thr(input logic deep, input logic [1:0] code);
    cnt_t t;
    if (deep) begin
      case (code)
        2'd0: t = cnt_t'(1);
        2'd1: t = cnt_t'(DEPTH_LG / 2);
        2'd2: t = cnt_t'(DEPTH_LG * 3 / 4);
        default: t = cnt_t'(DEPTH_LG);
      endcase
    end else begin
      case (code)
        2'd0: t = cnt_t'(1);
        2'd1: t = cnt_t'(3);
        2'd2: t = cnt_t'(6);
        default: t = cnt_t'(DEPTH_SM);
      endcase
    end
    return t;
  endfunction
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              deep,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output cnt_t              count
);
  logic [DATA_W-1:0] mem [DEPTH_LG];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [PTR_W-1:0]  last;

  assign last      = deep ? PTR_W'(DEPTH_LG - 1) : PTR_W'(DEPTH_SM - 1);
  assign head_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == last) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == last) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo_wdog.sv
module rx_fifo_wdog #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  input  logic nonempty,
  input  logic tick,
  output logic fired
);
  localparam int unsigned TW = $clog2(LIMIT);
  logic [TW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !enable) begin
      ticks <= '0;
      fired <= 1'b0;
    end else if (nonempty && tick && !fired) begin
      if (ticks == TW'(LIMIT - 1)) fired <= 1'b1;
      else                         ticks <= ticks + 1'b1;
    end
  end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WDOG_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_wr_en,
  input  logic [DATA_W-1:0] rx_wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              bit_tick,
  input  logic              depth_sel,
  input  logic              wdog_en,
  input  logic              lvl_hi,
  input  logic              lvl_lo,
  input  logic              ovr_clr,
  output logic [CNT_W-1:0]  fill_count,
  output logic              full,
  output logic              overrun,
  output logic              irq
);
  logic depth_q;
  logic flush, push, pop, wd_fired;
  cnt_t cap, count;

  assign flush = (depth_sel != depth_q);
  assign cap   = depth_q ? cnt_t'(DEPTH_LG) : cnt_t'(DEPTH_SM);
  assign full  = (count == cap);
  assign rd_valid = (count != '0);
  assign push  = rx_wr_en && !full && !flush;
  assign pop   = rd_valid && rd_ready && !flush;
  assign fill_count = count;

  always_ff @(posedge clk) begin
    if (!rst_n) depth_q <= 1'b0;
    else        depth_q <= depth_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           overrun <= 1'b0;
    else if (rx_wr_en && full && !flush)  overrun <= 1'b1;
    else if (ovr_clr)                     overrun <= 1'b0;
  end

  rx_fifo_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .deep(depth_q),
    .push(push), .push_data(rx_wr_data), .pop(pop),
    .head_data(rd_data), .count(count)
  );

  rx_fifo_wdog #(.LIMIT(WDOG_TICKS)) u_wdog (
    .clk(clk), .rst_n(rst_n), .restart(push || pop || flush),
    .enable(wdog_en), .nonempty(rd_valid), .tick(bit_tick),
    .fired(wd_fired)
  );

  assign irq = rd_valid &&
               ((count >= level_thr(depth_q, {lvl_hi, lvl_lo})) || wd_fired);
endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk
  import rx_fifo_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rx_wr_en,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       depth_sel,
  input logic       depth_q,
  input logic       ovr_clr,
  input logic [CNT_W-1:0] fill_count,
  input logic       full,
  input logic       overrun,
  input logic       irq
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= (depth_q ? CNT_W'(DEPTH_LG) : CNT_W'(DEPTH_SM))); // R1

  AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (fill_count != '0)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_wr_en && depth_sel == depth_q) |=> overrun); // R3

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun); // R3

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_sel != depth_q) |=> (fill_count == '0)); // R9

  AST_NO_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> !irq); // R10
endmodule

bind rx_fifo_irq rx_fifo_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_wr_en(rx_wr_en), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .depth_sel(depth_sel), .depth_q(depth_q),
  .ovr_clr(ovr_clr), .fill_count(fill_count), .full(full),
  .overrun(overrun), .irq(irq)
);

// File: tb/rx_fifo_irq_test.sv
`timescale 1ns/1ps
module rx_fifo_irq_test;
  logic clk = 0, rst_n = 0;
  logic wr = 0, rdy = 0, tick = 0, dsel = 0, wden = 0, lh = 0, ll = 0, clr = 0;
  logic [7:0] wdat = 0;
  logic rd_valid, full, overrun, irq;
  logic [7:0] rd_data;
  logic [4:0] fill_count;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] q[$];
  int  m_cnt = 0;
  logic m_depth = 0, m_ovr = 0, m_fired = 0;
  int  m_ticks = 0;

  always #2 clk = ~clk;

  rx_fifo_irq uut (
    .clk(clk), .rst_n(rst_n), .rx_wr_en(wr), .rx_wr_data(wdat),
    .rd_valid(rd_valid), .rd_ready(rdy), .rd_data(rd_data),
    .bit_tick(tick), .depth_sel(dsel), .wdog_en(wden), .lvl_hi(lh),
    .lvl_lo(ll), .ovr_clr(clr), .fill_count(fill_count), .full(full),
    .overrun(overrun), .irq(irq)
  );

  function automatic int cap_of(logic d);
    return d ? 16 : 8;
  endfunction

  function automatic int thr_of(logic d, logic [1:0] c);
    if (d) return (c == 0) ? 1 : (c == 1) ? 8 : (c == 2) ? 12 : 16;
    return (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? 6 : 8;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs with the model (called at negedge)
  task automatic check_all();
    int n = q.size();
    chk("R1 count", fill_count, n);
    chk("R1 full", full, n == cap_of(m_depth));
    chk("R2 valid", rd_valid, n != 0);
    if (n != 0) chk("R2 data", rd_data, q[0]);
    chk("R3 overrun", overrun, m_ovr);
    chk(m_fired ? "R6 irq" : (m_depth ? "R5 irq" : "R4 irq"), irq,
        (n != 0) && ((n >= thr_of(m_depth, {lh, ll})) || m_fired));
  endtask

  // advance the model over the coming edge with current inputs
  task automatic model_edge();
    bit fl = (dsel != m_depth);
    bit isfull = (q.size() == cap_of(m_depth));
    bit p = 0, o = 0;
    if (fl) begin
      q.delete(); m_depth = dsel; m_ticks = 0; m_fired = 0;
      if (clr) m_ovr = 0;
      return;
    end
    if (wr && isfull) m_ovr = 1; else if (clr) m_ovr = 0;
    o = rdy && q.size() != 0;
    p = wr && !isfull;
    if (o) void'(q.pop_front());
    if (p) q.push_back(wdat);
    if (p || o || !wden) begin m_ticks = 0; m_fired = 0; end
    else if (q.size() != 0 && tick && !m_fired) begin
      if (m_ticks == 63) m_fired = 1; else m_ticks++;
    end
  endtask

  task automatic step();
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    wr = 0; rdy = 0; clr = 0; tick = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all(); // reset state

    // R4: shallow thresholds, every code
    for (int c = 0; c < 4; c++) begin
      {lh, ll} = c[1:0];
      dsel = 1; idle(); step(); dsel = 0; step(); // flush via depth toggle (R9)
      for (int k = 0; k < 8; k++) begin wr = 1; wdat = 8'(k + 16*c); step(); end
      wr = 1; wdat = 8'hEE; step();             // R3 overflow drop
      idle(); clr = 1; step(); idle(); step();
    end

    // R5: deep thresholds, every code
    for (int c = 0; c < 4; c++) begin
      {lh, ll} = c[1:0];
      dsel = 0; idle(); step(); dsel = 1; step();
      for (int k = 0; k < 17; k++) begin wr = 1; wdat = 8'($urandom); step(); end
      idle(); rdy = 1;
      for (int k = 0; k < 16; k++) step();      // R2 drain in order
      idle(); step();
    end

    // R6 / R7 / R8: watchdog with code 11, deep
    {lh, ll} = 2'b11; wden = 1;
    wr = 1; wdat = 8'h5A; step(); idle();
    tick = 1;
    for (int k = 0; k < 63; k++) step();
    chk("R6 not yet", irq, 0);
    step();
    chk("R6 fired", irq, 1);
    tick = 0; step(); chk("R6 holds", irq, 1);
    wr = 1; wdat = 8'h11; step(); idle();
    chk("R7 restart", irq, 0);
    tick = 1;
    for (int k = 0; k < 40; k++) step();
    rdy = 1; step(); rdy = 0;                    // R7 pop restarts
    for (int k = 0; k < 63; k++) step();
    chk("R7 after pop", irq, 0);
    step(); chk("R7 fired after pop", irq, 1);
    wden = 0; step(); chk("R8 disabled", irq, 0);
    for (int k = 0; k < 80; k++) step();
    chk("R8 stays off", irq, 0);
    wden = 1;
    for (int k = 0; k < 30; k++) step();
    dsel = 0; step(); chk("R9 flushed", fill_count, 0); // R9
    chk("R10 empty", irq, 0);                   // R10
    idle();

    // random mix
    for (int i = 0; i < 6000; i++) begin
      wr   = ($urandom % 100) < 55;
      wdat = 8'($urandom);
      rdy  = ($urandom % 100) < 40;
      tick = ($urandom % 100) < 30;
      clr  = ($urandom % 100) < 5;
      wden = ($urandom % 100) < 90;
      lh   = 1'($urandom); ll = 1'($urandom);
      if (($urandom % 500) == 0) dsel = ~dsel;
      if (($urandom % 300) == 0) begin wr = 0; rdy = 0; end
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule